// File: doc/BRIEF.md
# Oscillator Stabilization Delay Timer

This block derives every oscillator settling delay of a microcontroller from a single 12-bit counter that advances on the falling edge of the oscillator clock. When power comes up, it holds the external reset pin low for a full counter period. After a further short interval it lets the CPU out of reset and turns on the bus clocks.

The same counter times the wake-up from stop mode. A stop strobe clears it and holds it at zero while the part sleeps. A wake-up event then starts either a short or a long recovery count, selected by a configuration bit, and the bus clocks come back when that count ends. Each time the counter wraps from all ones to zero it emits a one-cycle tick, which serves as the prescaled clock for a watchdog.

The watchdog and the CPU sit outside this block. All delays are parameters, and the defaults are a 4096-cycle pin hold, a 64-cycle CPU gap, a 32-cycle short recovery and a 4096-cycle long recovery.

Top module: `stab_delay_timer`

## Requirements
- R1: While no clear is in effect, the counter advances by one on every falling edge of `osc_clk` and runs freely. In the run state, `wdog_tick` pulses once every 4096 falling edges.
- R2: After `por_req` is released, `rst_pin_n` stays low for exactly 4096 falling edges and goes high on the 4096th.
- R3: `cpu_rst_n` goes high exactly 64 falling edges after `rst_pin_n` goes high. `bus_clk_en` goes high on the same edge.
- R4: A `stop_req` seen on a falling edge in the run state clears the counter and drops `bus_clk_en` on that edge. The counter is then held at zero until the recovery count starts.
- R5: With `short_rec` = 1 at the wake edge, `bus_clk_en` returns exactly 32 falling edges after the falling edge that sees `wake_req`.
- R6: With `short_rec` = 0 at the wake edge, `bus_clk_en` returns exactly 4096 falling edges after the wake edge.
- R7: `short_rec` is captured only on the wake edge. Changing it during the recovery count does not change the recovery length.
- R8: `wake_req` is ignored outside the stopped state, including during recovery. `stop_req` is ignored outside the run state.
- R9: `wdog_tick` is a single-cycle pulse that is high only on the edge where the counter wraps from all ones to zero.
- R10: Asserting `por_req` at any time, including during stop recovery, clears the counter at once and restarts the full power-on sequence of R2 and R3.
- R11: While `por_req` is high, `rst_pin_n`, `cpu_rst_n`, `bus_clk_en` and `wdog_tick` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock. All state advances on its falling edge. |
| por_req | input | 1 | Asynchronous power-on reset request, active high. |
| stop_req | input | 1 | Stop entry strobe, sampled on falling edges. |
| wake_req | input | 1 | Wake-up event from interrupt, break or reset, sampled on falling edges. |
| short_rec | input | 1 | Recovery length select: 1 selects the short recovery, 0 the long one. |
| rst_pin_n | output | 1 | Drive for the external reset pin, active low. |
| cpu_rst_n | output | 1 | CPU reset, active low. |
| bus_clk_en | output | 1 | Enable for the internal bus clocks. |
| wdog_tick | output | 1 | One-cycle pulse on each counter wrap, used as the watchdog clock. |

## Verification
The assertions assume that `stop_req`, `wake_req` and `short_rec` are synchronous to `osc_clk` and settle well away from its falling edge. The only input allowed to change asynchronously is `por_req`, and every clocked property is disabled while it is high. The bench drives all inputs one nanosecond after the rising edge and holds each strobe for a whole clock period, so every strobe is seen on exactly one falling edge. It issues a `por_req` in the middle of a recovery and keeps it high for several cycles before releasing it. It also pulses `stop_req` and `wake_req` in states where they must have no effect.

// File: rtl/stab_delay_pkg.sv
package stab_delay_pkg;

   typedef enum logic [2:0] {
      SEQ_PORHOLD = 3'd0,
      SEQ_PORGAP  = 3'd1,
      SEQ_RUN     = 3'd2,
      SEQ_STOPPED = 3'd3,
      SEQ_WAKING  = 3'd4
   } seq_state_t;

   // indices of the count targets decoded by the sequencer
   localparam int unsigned TGT_HOLD  = 0;
   localparam int unsigned TGT_GAP   = 1;
   localparam int unsigned TGT_SHORT = 2;
   localparam int unsigned TGT_LONG  = 3;
   localparam int unsigned TGT_NUM   = 4;

endpackage

// File: rtl/sdt_counter.sv
module sdt_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2 || CNT_W > 30) begin : g_bad_width
         $error("sdt_counter: CNT_W out of range");
      end
   endgenerate

   always_ff @(negedge clk_i or posedge por_i) begin
      if (por_i) begin
         cnt_o  <= '0;
         wrap_o <= 1'b0;
      end else begin
         cnt_o  <= clr_i ? '0 : (cnt_o + ONE);
         wrap_o <= !clr_i && (cnt_o == ONES);
      end
   end

   // R1
   count_step_chk: assert property (@(negedge clk_i) disable iff (por_i)
      !clr_i |=> (cnt_o == CNT_W'($past(cnt_o) + ONE)));

   // R9
   tick_width_chk: assert property (@(negedge clk_i) disable iff (por_i)
      wrap_o |=> !wrap_o);

   // R9
   tick_at_zero_chk: assert property (@(negedge clk_i) disable iff (por_i)
      wrap_o |-> (cnt_o == '0));

endmodule

// File: rtl/sdt_match.sv
module sdt_match #(
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned TARGET = 0
) (
   input  logic [CNT_W-1:0] cnt_i,
   output logic             hit_o
);

   localparam int unsigned     MOD   = 1 << CNT_W;
   localparam logic [CNT_W-1:0] TGT_V = CNT_W'(TARGET);

   generate
      if (TARGET >= MOD) begin : g_bad_target
         $error("sdt_match: TARGET does not fit the counter");
      end
      if (TARGET == MOD - 1) begin : g_all_ones
         assign hit_o = &cnt_i;
      end else if (TARGET == 0) begin : g_zero
         assign hit_o = ~|cnt_i;
      end else begin : g_compare
         assign hit_o = (cnt_i == TGT_V);
      end
   endgenerate

endmodule

// File: rtl/sdt_sequencer.sv
module sdt_sequencer
   import stab_delay_pkg::*;
#(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned HOLD_CYC  = 4096,
   parameter int unsigned GAP_CYC   = 64,
   parameter int unsigned SHORT_CYC = 32,
   parameter int unsigned LONG_CYC  = 4096
) (
   input  logic             clk_i,
   input  logic             por_i,
   input  logic             stop_i,
   input  logic             wake_i,
   input  logic             short_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic             clr_o,
   output logic             rst_pin_n_o,
   output logic             cpu_rst_n_o,
   output logic             bus_clk_en_o
);

   localparam int unsigned MOD = 1 << CNT_W;
   localparam logic [CNT_W-1:0] AT_PIN   = CNT_W'(HOLD_CYC % MOD);
   localparam logic [CNT_W-1:0] AT_CPU   = CNT_W'((HOLD_CYC + GAP_CYC) % MOD);
   localparam logic [CNT_W-1:0] AT_SHORT = CNT_W'(SHORT_CYC % MOD);
   localparam logic [CNT_W-1:0] AT_LONG  = CNT_W'(LONG_CYC % MOD);

   function automatic int unsigned tgt_of(input int unsigned k);
      case (k)
         TGT_HOLD:  return (HOLD_CYC - 1) % MOD;
         TGT_GAP:   return (HOLD_CYC + GAP_CYC - 1) % MOD;
         TGT_SHORT: return (SHORT_CYC - 1) % MOD;
         default:   return (LONG_CYC - 1) % MOD;
      endcase
   endfunction

   generate
      if (HOLD_CYC < 1 || HOLD_CYC > MOD) begin : g_bad_hold
         $error("sdt_sequencer: HOLD_CYC must lie in 1..2**CNT_W");
      end
      if (GAP_CYC < 1 || GAP_CYC > MOD) begin : g_bad_gap
         $error("sdt_sequencer: GAP_CYC must lie in 1..2**CNT_W");
      end
      if (SHORT_CYC < 1 || SHORT_CYC > MOD) begin : g_bad_short
         $error("sdt_sequencer: SHORT_CYC must lie in 1..2**CNT_W");
      end
      if (LONG_CYC < 1 || LONG_CYC > MOD) begin : g_bad_long
         $error("sdt_sequencer: LONG_CYC must lie in 1..2**CNT_W");
      end
   endgenerate

   logic [TGT_NUM-1:0] hit;

   generate
      for (genvar k = 0; k < TGT_NUM; k++) begin : g_match
         sdt_match #(
            .CNT_W  (CNT_W),
            .TARGET (tgt_of(k))
         ) u_match (
            .cnt_i (cnt_i),
            .hit_o (hit[k])
         );
      end
   endgenerate

   seq_state_t state_q, state_d;
   logic       short_q;
   logic       rec_done;

   assign rec_done = short_q ? hit[TGT_SHORT] : hit[TGT_LONG];

   always_comb begin
      state_d = state_q;
      case (state_q)
         SEQ_PORHOLD: if (hit[TGT_HOLD]) state_d = SEQ_PORGAP;
         SEQ_PORGAP:  if (hit[TGT_GAP])  state_d = SEQ_RUN;
         SEQ_RUN:     if (stop_i)        state_d = SEQ_STOPPED;
         SEQ_STOPPED: if (wake_i)        state_d = SEQ_WAKING;
         SEQ_WAKING:  if (rec_done)      state_d = SEQ_RUN;
         default:                        state_d = SEQ_PORHOLD;
      endcase
   end

   always_ff @(negedge clk_i or posedge por_i) begin
      if (por_i) begin
         state_q <= SEQ_PORHOLD;
         short_q <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == SEQ_STOPPED && wake_i) short_q <= short_i;
      end
   end

   assign clr_o        = (state_q == SEQ_STOPPED) || (state_q == SEQ_RUN && stop_i);
   assign rst_pin_n_o  = (state_q != SEQ_PORHOLD);
   assign cpu_rst_n_o  = (state_q != SEQ_PORHOLD) && (state_q != SEQ_PORGAP);
   assign bus_clk_en_o = (state_q == SEQ_RUN);

   // R2
   pin_release_chk: assert property (@(negedge clk_i) disable iff (por_i)
      $rose(rst_pin_n_o) |-> (cnt_i == AT_PIN));

   // R3
   cpu_release_chk: assert property (@(negedge clk_i) disable iff (por_i)
      $rose(cpu_rst_n_o) |-> (cnt_i == AT_CPU));

   // R4
   stop_clear_chk: assert property (@(negedge clk_i) disable iff (por_i)
      (state_q == SEQ_RUN && stop_i) |=> (cnt_i == '0 && !bus_clk_en_o));

   // R5
   wake_len_chk: assert property (@(negedge clk_i) disable iff (por_i)
      ($rose(bus_clk_en_o) && $past(state_q) == SEQ_WAKING)
         |-> (cnt_i == (short_q ? AT_SHORT : AT_LONG)));

   // R7
   short_hold_chk: assert property (@(negedge clk_i) disable iff (por_i)
      (state_q == SEQ_WAKING) |=> $stable(short_q));

   // R8
   wake_ignored_chk: assert property (@(negedge clk_i) disable iff (por_i)
      (state_q == SEQ_WAKING) |=> (state_q == SEQ_WAKING || state_q == SEQ_RUN));

endmodule

// File: rtl/stab_delay_timer.sv
module stab_delay_timer #(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned HOLD_CYC  = 4096,
   parameter int unsigned GAP_CYC   = 64,
   parameter int unsigned SHORT_CYC = 32,
   parameter int unsigned LONG_CYC  = 4096
) (
   input  logic osc_clk,
   input  logic por_req,
   input  logic stop_req,
   input  logic wake_req,
   input  logic short_rec,
   output logic rst_pin_n,
   output logic cpu_rst_n,
   output logic bus_clk_en,
   output logic wdog_tick
);

   logic [CNT_W-1:0] cnt;
   logic             clr;

   sdt_counter #(
      .CNT_W (CNT_W)
   ) u_counter (
      .clk_i  (osc_clk),
      .por_i  (por_req),
      .clr_i  (clr),
      .cnt_o  (cnt),
      .wrap_o (wdog_tick)
   );

   sdt_sequencer #(
      .CNT_W     (CNT_W),
      .HOLD_CYC  (HOLD_CYC),
      .GAP_CYC   (GAP_CYC),
      .SHORT_CYC (SHORT_CYC),
      .LONG_CYC  (LONG_CYC)
   ) u_seq (
      .clk_i        (osc_clk),
      .por_i        (por_req),
      .stop_i       (stop_req),
      .wake_i       (wake_req),
      .short_i      (short_rec),
      .cnt_i        (cnt),
      .clr_o        (clr),
      .rst_pin_n_o  (rst_pin_n),
      .cpu_rst_n_o  (cpu_rst_n),
      .bus_clk_en_o (bus_clk_en)
   );

   // R11
   por_quiet_chk: assert property (@(negedge osc_clk)
      por_req |-> (!rst_pin_n && !cpu_rst_n && !bus_clk_en && !wdog_tick));

endmodule

// File: tb/test_stab_delay_timer.sv
module test_stab_delay_timer;

   localparam int W      = 12;
   localparam int MODV   = 1 << W;
   localparam int HOLD   = 4096;
   localparam int GAP    = 64;
   localparam int SHORTD = 32;
   localparam int LONGD  = 4096;
   localparam int LIMIT  = 20000;

   logic clk = 1'b0;
   logic por = 1'b0;
   logic stop = 1'b0;
   logic wake = 1'b0;
   logic shrt = 1'b0;
   logic rst_pin_n, cpu_rst_n, bus_clk_en, wdog_tick;

   always #10 clk = ~clk;

   stab_delay_timer i_stab_delay_timer (
      .osc_clk    (clk),
      .por_req    (por),
      .stop_req   (stop),
      .wake_req   (wake),
      .short_rec  (shrt),
      .rst_pin_n  (rst_pin_n),
      .cpu_rst_n  (cpu_rst_n),
      .bus_clk_en (bus_clk_en),
      .wdog_tick  (wdog_tick)
   );

   int    checks = 0;
   int    errors = 0;
   string cur_req = "R11";

   // behavioural reference: phase 0 hold, 1 gap, 2 run, 3 stopped, 4 waking
   int   m_cnt = 0;
   int   m_ph  = 0;
   int   m_rem = HOLD;
   logic m_tick = 1'b0;

   always @(negedge clk or posedge por) begin
      if (por) begin
         m_cnt  = 0;
         m_ph   = 0;
         m_rem  = HOLD;
         m_tick = 1'b0;
      end else begin
         bit clr;
         clr    = (m_ph == 2 && stop) || (m_ph == 3);
         m_tick = !clr && (m_cnt == MODV - 1);
         m_cnt  = clr ? 0 : (m_cnt + 1) % MODV;
         case (m_ph)
            0: begin m_rem--; if (m_rem == 0) begin m_ph = 1; m_rem = GAP; end end
            1: begin m_rem--; if (m_rem == 0) m_ph = 2; end
            2: if (stop) m_ph = 3;
            3: if (wake) begin m_ph = 4; m_rem = shrt ? SHORTD : LONGD; end
            4: begin m_rem--; if (m_rem == 0) m_ph = 2; end
            default: m_ph = 0;
         endcase
      end
   end

   task automatic chk(input logic act, input logic exp, input string req, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s (%s) %s: actual %b expected %b", req, cur_req, what, act, exp);
      end
   endtask

   task automatic chk_int(input int act, input int exp, input string req, input string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // per-clock comparison against the reference
   always @(posedge clk) begin
      chk(rst_pin_n,  m_ph != 0,           "R2",  "rst_pin_n");
      chk(cpu_rst_n,  m_ph >= 2,           "R3",  "cpu_rst_n");
      chk(bus_clk_en, m_ph == 2,           "R4",  "bus_clk_en");
      chk(wdog_tick,  m_tick,              "R9",  "wdog_tick");
   end

   function automatic logic pick(input int which);
      case (which)
         0: return rst_pin_n;
         1: return cpu_rst_n;
         2: return bus_clk_en;
         default: return wdog_tick;
      endcase
   endfunction

   task automatic count_low(input int which, output int lows);
      lows = 0;
      while (!pick(which) && lows < LIMIT) begin
         lows++;
         @(posedge clk); #1;
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic pulse_stop();
      stop = 1'b1; step(1); stop = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1; step(1); wake = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int n;
      #1 por = 1'b1;
      step(3);
      // R11: all outputs quiet during power-on request
      chk(rst_pin_n,  1'b0, "R11", "reset rst_pin_n");
      chk(cpu_rst_n,  1'b0, "R11", "reset cpu_rst_n");
      chk(bus_clk_en, 1'b0, "R11", "reset bus_clk_en");
      chk(wdog_tick,  1'b0, "R11", "reset wdog_tick");

      // R2 / R3: power-on sequence
      cur_req = "R2";
      por = 1'b0;
      count_low(0, n);
      chk_int(n, HOLD, "R2", "pin low cycles");
      cur_req = "R3";
      count_low(1, n);
      chk_int(n, GAP, "R3", "cpu gap cycles");
      chk(bus_clk_en, 1'b1, "R3", "bus on with cpu release");

      // R1 / R9: free-running tick period and width
      cur_req = "R1";
      count_low(3, n);
      step(1);
      chk(wdog_tick, 1'b0, "R9", "tick width one cycle");
      count_low(3, n);
      chk_int(n + 1, MODV, "R1", "tick period");

      // R8: wake in run state has no effect
      cur_req = "R8";
      pulse_wake();
      step(3);
      chk(bus_clk_en, 1'b1, "R8", "wake ignored in run");

      // R4 / R5: stop then short recovery
      cur_req = "R4";
      shrt = 1'b1;
      pulse_stop();
      chk(bus_clk_en, 1'b0, "R4", "bus off after stop");
      step(20);
      chk(wdog_tick, 1'b0, "R4", "no tick while stopped");
      cur_req = "R5";
      pulse_wake();
      count_low(2, n);
      chk_int(n, SHORTD, "R5", "short recovery cycles");

      // R6: long recovery
      cur_req = "R6";
      shrt = 1'b0;
      step(5);
      pulse_stop();
      step(7);
      pulse_wake();
      count_low(2, n);
      chk_int(n, LONGD, "R6", "long recovery cycles");

      // R7 / R8: bit change and repeat wake during recovery
      cur_req = "R7";
      step(5);
      pulse_stop();
      step(4);
      pulse_wake();
      shrt = 1'b1;
      n = 0;
      while (!bus_clk_en && n < LIMIT) begin
         wake = (n == 100);
         n++;
         @(posedge clk); #1;
      end
      wake = 1'b0;
      chk_int(n, LONGD, "R7", "recovery length fixed at wake");
      // R8: stop ignored during power-on hold, R10: power-on during recovery
      cur_req = "R10";
      shrt = 1'b0;
      step(5);
      pulse_stop();
      step(3);
      pulse_wake();
      step(200);
      por = 1'b1;
      step(3);
      chk(rst_pin_n, 1'b0, "R10", "pin low on restart");
      por = 1'b0;
      n = 0;
      while (!rst_pin_n && n < LIMIT) begin
         stop = (n == 10);
         n++;
         @(posedge clk); #1;
      end
      stop = 1'b0;
      chk_int(n, HOLD, "R10", "pin hold after restart");
      count_low(1, n);
      chk_int(n, GAP, "R10", "cpu gap after restart");
      chk(bus_clk_en, 1'b1, "R8", "stop during hold ignored");

      step(20);
      finish_run();
   end

endmodule